// File: doc/BRIEF.md
# Averaging ADC Step Sequencer

This block drives a shared analog-to-digital converter through a list of up to sixteen programmable conversion steps. Each step has its own configuration word and its own delay word. The configuration word gives the input pair, the number of samples to average, the result queue and the step mode. The delay word gives an open (settling) delay and a per-sample delay. The sequencer visits the enabled steps from the lowest index to the highest. For each step it waits out the open delay and then, for each sample, waits out the sample delay and runs one conversion. It then writes the averaged, step-tagged result into one of two result queues.

The converter is a stub built into the block. It uses a start/done handshake and each conversion takes `CONV_CYCLES` clocks. A sample is `level[pos] - level[neg] + k`, truncated to 12 bits, where `k` is the sample's index within the step (0, 1, ...). The per-channel levels come in on a port, and an input select of 8 or higher reads as 0. Interrupt flags are sticky and write-one-to-clear. They report end of sequence and, for each queue, threshold, overrun and underflow.

Top module: `adc_step_seq`

## Requirements
- R1: After reset, `busy`, `irq_status`, `step_en` and both queue counts are zero, and an empty queue reads zero.
- R2: A sequence starts only while `seq_enable` is 1 and at least one `step_en` bit is set. Enabled steps run in ascending index order, and disabled steps produce no result.
- R3: Config bits [1:0] hold the mode. In mode 1 (continuous) the step's enable bit stays set, and a new sequence starts from the lowest enabled step after end of sequence. In every other mode the step's enable bit clears when its result is stored.
- R4: Config bits [4:2] hold the averaging code c, clamped to 4. The step takes 2^c samples, and its result is the 16-bit sum of the 12-bit samples shifted right by c, keeping 12 bits.
- R5: A result word has the average in bits [11:0]. Bits [19:16] hold the step index when `tag_enable` is 1 and zero otherwise. All other bits are zero.
- R6: Config bit 26 routes the result to queue 1 when set and to queue 0 when clear. Config bits [22:19] select the positive input and bits [18:15] the negative input.
- R7: Delay bits [17:0] hold the open delay D and bits [31:24] the sample delay S. The number of cycles from the first busy cycle of a lone step to its queue count changing lies between D + N*(S+13) and that value plus 3N+4, where N is the sample count.
- R8: In mode 2 a step holds after arming until `hw_trig` is high, then runs.
- R9: `power_down` aborts the step in progress. No result is written and `busy` is 0 in the next cycle. No sequence starts while `power_down` is 1 or `seq_enable` is 0.
- R10: When the last enabled step of a pass stores its result, `irq_status[1]` sets and `busy` falls in the same cycle.
- R11: `irq_status[2]` (queue 0) or `irq_status[5]` (queue 1) sets while that queue's threshold is non-zero and its count is at least the threshold.
- R12: A result pushed into a full queue is dropped and sets `irq_status[3]` (queue 0) or `irq_status[6]` (queue 1).
- R13: A pop of an empty queue reads zero and sets `irq_status[4]` (queue 0) or `irq_status[7]` (queue 1).
- R14: Writing 1 to a bit of `irq_clr` clears that flag. A new event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_enable | input | 1 | Allows sequences to start |
| tag_enable | input | 1 | Puts the step index into result words |
| power_down | input | 1 | Aborts and holds off sequencing |
| hw_trig | input | 1 | Release for mode-2 steps |
| step_en_wr | input | 1 | Loads `step_en_wdata` into the enable mask |
| step_en_wdata | input | NSTEPS | New enable mask |
| step_en | output | NSTEPS | Current enable mask |
| step_cfg | input | NSTEPS*32 | Configuration words, step i at [32i+31:32i] |
| step_dly | input | NSTEPS*32 | Delay words, step i at [32i+31:32i] |
| chan_level | input | NCHAN*DW | Stub converter level per channel |
| fifo_pop | input | 2 | Pop strobe per queue |
| fifo_thresh0 | input | CW | Queue 0 threshold (0 disables) |
| fifo_thresh1 | input | CW | Queue 1 threshold (0 disables) |
| fifo0_rdata | output | 32 | Head of queue 0 |
| fifo1_rdata | output | 32 | Head of queue 1 |
| fifo0_count | output | CW | Words in queue 0 |
| fifo1_count | output | CW | Words in queue 1 |
| irq_clr | input | 8 | Write-one-to-clear flags |
| irq_status | output | 8 | Sticky interrupt flags |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and keeps the other parameters at their defaults: sixteen steps, eight channels and a 13-cycle conversion. The shallow queues let a continuous step overrun queue 0 within a few hundred cycles. They also let a threshold of 2 be crossed with a mixed step sequence, and let the queue be drained back to underflow. The averaging case uses the clamped code of 16 samples on a negative difference, so the wrap of each 12-bit sample is covered. Short delays keep each pass brief, and a 40-cycle open delay checks the timing window.

// File: rtl/adcseq_pkg.sv
// Package: shared state encoding and field positions for the step sequencer.
// Assumes 32-bit configuration and delay words.
package adcseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ARM, ST_TRIG, ST_OPEN, ST_SDLY, ST_CONV, ST_STORE
    } seq_state_e;

    localparam int WORD_W   = 32;
    localparam int SEL_W    = 4;
    localparam int F_MODE   = 0;
    localparam int F_AVG    = 2;
    localparam int F_NEG    = 15;
    localparam int F_POS    = 19;
    localparam int F_QSEL   = 26;
    localparam int D_OPEN   = 0;
    localparam int D_SDLY   = 24;
    localparam int R_TAG    = 16;
    localparam logic [1:0] MODE_CONT   = 2'd1;
    localparam logic [1:0] MODE_HWSYNC = 2'd2;
endpackage

// File: rtl/adcseq_conv_stub.sv
// Converter stub: after a start pulse, returns level[pos]-level[neg]+idx
// with a one-cycle done pulse CONV_CYCLES+1 clocks later.
// Assumes start is not re-issued while a conversion is running.
module adcseq_conv_stub import adcseq_pkg::*; #(
    parameter int NCHAN       = 8,
    parameter int DW          = 12,
    parameter int IDX_W       = 4,
    parameter int CONV_CYCLES = 13,
    localparam int CNT_W      = $clog2(CONV_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SEL_W-1:0]    pos_sel,
    input  logic [SEL_W-1:0]    neg_sel,
    input  logic [IDX_W-1:0]    idx,
    input  logic [NCHAN*DW-1:0] levels,
    output logic                done,
    output logic [DW-1:0]       data
);
    logic [DW-1:0]    lvl_p, lvl_n, held;
    logic [CNT_W-1:0] cnt;
    logic             active;

    // Pick the two levels; selects outside the channel range read as zero.
    always_comb begin
        lvl_p = '0;
        lvl_n = '0;
        for (int c = 0; c < NCHAN; c++) begin
            if (pos_sel == SEL_W'(c)) lvl_p = levels[c*DW +: DW];
            if (neg_sel == SEL_W'(c)) lvl_n = levels[c*DW +: DW];
        end
    end

    // Count out the conversion time and present the result with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            held   <= '0;
            done   <= 1'b0;
            data   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cnt    <= CNT_W'(CONV_CYCLES - 1);
                held   <= lvl_p - lvl_n + DW'(idx);
            end else if (active) begin
                if (cnt == '0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    data   <= held;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adcseq_step_pick.sv
// Lowest-set-bit finder over the candidate step mask.
// Purely combinational; idx is zero when nothing is found.
module adcseq_step_pick #(
    parameter int NSTEPS = 16,
    localparam int SW    = $clog2(NSTEPS)
) (
    input  logic [NSTEPS-1:0] cand,
    output logic              found,
    output logic [SW-1:0]     idx
);
    // Scan from the top so the lowest set bit is the last one to win.
    always_comb begin
        idx = '0;
        for (int i = NSTEPS - 1; i >= 0; i--) begin
            if (cand[i]) idx = SW'(i);
        end
        found = |cand;
    end
endmodule

// File: rtl/adcseq_fifo.sv
// Result queue with show-ahead head, drop-on-full and zero-on-empty reads.
// Reports overrun and underflow as single-cycle pulses.
module adcseq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic          udf
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf     = push && full;
    assign udf     = pop && empty;
    assign rdata   = empty ? '0 : mem[rp];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Move the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/adc_step_seq.sv
// Step sequencer: walks the enabled steps in ascending order. For each
// step it waits out the open delay, then for each sample waits the sample
// delay and runs one stub conversion. It averages the samples and pushes
// a tagged result into queue 0 or 1.
// Assumes AVG_MAX <= 7, NSTEPS <= 16 and DW <= 16.
module adc_step_seq import adcseq_pkg::*; #(
    parameter int NSTEPS      = 16,
    parameter int NCHAN       = 8,
    parameter int DW          = 12,
    parameter int AVG_MAX     = 4,
    parameter int OPEN_W      = 18,
    parameter int SDLY_W      = 8,
    parameter int CONV_CYCLES = 13,
    parameter int FIFO_DEPTH  = 16,
    localparam int SW         = $clog2(NSTEPS),
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    seq_enable,
    input  logic                    tag_enable,
    input  logic                    power_down,
    input  logic                    hw_trig,
    input  logic                    step_en_wr,
    input  logic [NSTEPS-1:0]       step_en_wdata,
    output logic [NSTEPS-1:0]       step_en,
    input  logic [NSTEPS*32-1:0]    step_cfg,
    input  logic [NSTEPS*32-1:0]    step_dly,
    input  logic [NCHAN*DW-1:0]     chan_level,
    input  logic [1:0]              fifo_pop,
    input  logic [CW-1:0]           fifo_thresh0,
    input  logic [CW-1:0]           fifo_thresh1,
    output logic [31:0]             fifo0_rdata,
    output logic [31:0]             fifo1_rdata,
    output logic [CW-1:0]           fifo0_count,
    output logic [CW-1:0]           fifo1_count,
    input  logic [7:0]              irq_clr,
    output logic [7:0]              irq_status,
    output logic                    busy
);
    localparam int ACC_W = DW + AVG_MAX;

    seq_state_e          st;
    logic [SW-1:0]       cur;
    logic [OPEN_W-1:0]   cnt;
    logic [AVG_MAX-1:0]  smp;
    logic [ACC_W-1:0]    acc;
    logic [NSTEPS-1:0]   mask;
    logic                conv_start, conv_done;
    logic [DW-1:0]       conv_data;

    logic [WORD_W-1:0]   cfg, dly;
    logic [1:0]          mode;
    logic [2:0]          code_raw, code;
    logic [AVG_MAX-1:0]  n_last;
    logic [OPEN_W-1:0]   open_dly, samp_dly;
    logic [NSTEPS-1:0]   above, mask_done, cand;
    logic                pick_found;
    logic [SW-1:0]       pick_idx;
    logic [DW-1:0]       avg_val;
    logic [WORD_W-1:0]   res_word;
    logic                storing, eos;

    logic [1:0]          q_push, q_ovf, q_udf, q_thr;
    logic [WORD_W-1:0]   q_rdata [2];
    logic [CW-1:0]       q_count [2];
    logic [CW-1:0]       q_thresh [2];

    // Decode the fields of the current step.
    always_comb begin
        cfg      = step_cfg[cur*WORD_W +: WORD_W];
        dly      = step_dly[cur*WORD_W +: WORD_W];
        mode     = cfg[F_MODE +: 2];
        code_raw = cfg[F_AVG +: 3];
        code     = (code_raw > 3'(AVG_MAX)) ? 3'(AVG_MAX) : code_raw;
        n_last   = AVG_MAX'((1 << code) - 1);
        open_dly = dly[D_OPEN +: OPEN_W];
        samp_dly = OPEN_W'(dly[D_SDLY +: SDLY_W]);
    end

    // Work out the next step candidates and the result word.
    always_comb begin
        above     = ({NSTEPS{1'b1}} << cur) << 1;
        mask_done = (mode == MODE_CONT) ? mask : (mask & ~(NSTEPS'(1) << cur));
        cand      = (st == ST_IDLE) ? mask : (mask_done & above);
        avg_val   = DW'(acc >> code);
        res_word  = '0;
        res_word[DW-1:0]   = avg_val;
        res_word[R_TAG +: 4] = tag_enable ? 4'(cur) : 4'b0;
        storing   = (st == ST_STORE) && !power_down;
        eos       = storing && !pick_found;
    end

    adcseq_step_pick #(.NSTEPS(NSTEPS)) u_pick (
        .cand  (cand),
        .found (pick_found),
        .idx   (pick_idx)
    );

    adcseq_conv_stub #(
        .NCHAN(NCHAN), .DW(DW), .IDX_W(AVG_MAX), .CONV_CYCLES(CONV_CYCLES)
    ) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (conv_start),
        .pos_sel (cfg[F_POS +: SEL_W]),
        .neg_sel (cfg[F_NEG +: SEL_W]),
        .idx     (smp),
        .levels  (chan_level),
        .done    (conv_done),
        .data    (conv_data)
    );

    // Sequencer state machine: arm, trigger, open delay, samples, store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cur        <= '0;
            cnt        <= '0;
            smp        <= '0;
            acc        <= '0;
            conv_start <= 1'b0;
        end else if (power_down) begin
            st         <= ST_IDLE;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            unique case (st)
                ST_IDLE: if (seq_enable && pick_found) begin
                    cur <= pick_idx;
                    st  <= ST_ARM;
                end
                ST_ARM: begin
                    cnt <= open_dly;
                    smp <= '0;
                    acc <= '0;
                    st  <= (mode == MODE_HWSYNC) ? ST_TRIG : ST_OPEN;
                end
                ST_TRIG: if (hw_trig) st <= ST_OPEN;
                ST_OPEN: begin
                    if (cnt == '0) begin
                        cnt <= samp_dly;
                        st  <= ST_SDLY;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SDLY: begin
                    if (cnt == '0) begin
                        conv_start <= 1'b1;
                        st         <= ST_CONV;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_CONV: if (conv_done) begin
                    acc <= acc + ACC_W'(conv_data);
                    if (smp == n_last) begin
                        st <= ST_STORE;
                    end else begin
                        smp <= smp + 1'b1;
                        cnt <= samp_dly;
                        st  <= ST_SDLY;
                    end
                end
                ST_STORE: begin
                    if (pick_found) begin
                        cur <= pick_idx;
                        st  <= ST_ARM;
                    end else begin
                        st  <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Step enable mask: a write wins over the one-shot clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask <= '0;
        else if (step_en_wr) mask <= step_en_wdata;
        else if (storing)    mask <= mask_done;
    end

    assign q_thresh[0] = fifo_thresh0;
    assign q_thresh[1] = fifo_thresh1;

    // One result queue per destination, selected by the routing bit.
    for (genvar q = 0; q < 2; q++) begin : g_queue
        assign q_push[q] = storing && (cfg[F_QSEL] == 1'(q));
        assign q_thr[q]  = (q_thresh[q] != '0) && (q_count[q] >= q_thresh[q]);
        adcseq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[q]),
            .wdata (res_word),
            .pop   (fifo_pop[q]),
            .rdata (q_rdata[q]),
            .count (q_count[q]),
            .ovf   (q_ovf[q]),
            .udf   (q_udf[q])
        );
    end

    // Sticky flags: events set, write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_status <= '0;
        else irq_status <= (irq_status & ~irq_clr) |
            {q_udf[1], q_ovf[1], q_thr[1], q_udf[0], q_ovf[0], q_thr[0], eos, 1'b0};
    end

    assign fifo0_rdata = q_rdata[0];
    assign fifo1_rdata = q_rdata[1];
    assign fifo0_count = q_count[0];
    assign fifo1_count = q_count[1];
    assign step_en     = mask;
    assign busy        = (st != ST_IDLE);
endmodule

// File: rtl/adcseq_checker.sv
// Checker: temporal properties on the sequencer ports, bound to the top.
module adcseq_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          power_down,
    input logic          busy,
    input logic [7:0]    irq_status,
    input logic [1:0]    fifo_pop,
    input logic [CW-1:0] fifo0_count,
    input logic [CW-1:0] fifo1_count,
    input logic [CW-1:0] fifo_thresh0,
    input logic [31:0]   fifo0_rdata
);
    p_pd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> !busy);
    p_eos_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(power_down)) |-> irq_status[1]);
    p_thresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[2]) |-> ($past(fifo_thresh0) != '0 &&
                                  $past(fifo0_count) >= $past(fifo_thresh0)));
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo0_count <= CW'(DEPTH)) && (fifo1_count <= CW'(DEPTH)));
    p_ovf_when_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[3]) |-> $past(fifo0_count) == CW'(DEPTH));
    p_udf_on_empty_pop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[4]) |-> ($past(fifo_pop[0]) && $past(fifo0_count) == '0));
    p_empty_reads_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo0_count == '0) |-> (fifo0_rdata == '0));
    p_word_layout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo0_rdata[31:20] == '0) && (fifo0_rdata[15:12] == '0));
endmodule

bind adc_step_seq adcseq_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .power_down   (power_down),
    .busy         (busy),
    .irq_status   (irq_status),
    .fifo_pop     (fifo_pop),
    .fifo0_count  (fifo0_count),
    .fifo1_count  (fifo1_count),
    .fifo_thresh0 (fifo_thresh0),
    .fifo0_rdata  (fifo0_rdata)
);

// File: tb/tb_adc_step_seq.sv
// Directed bench for the step sequencer; each task checks its own scenario.
module tb_adc_step_seq;
    localparam int NS = 16, NC = 8, DW = 12, DEPTH = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic seq_enable = 0, tag_enable = 0, power_down = 0, hw_trig = 0;
    logic step_en_wr = 0;
    logic [NS-1:0] step_en_wdata = '0, step_en;
    logic [NS*32-1:0] step_cfg = '0, step_dly = '0;
    logic [NC*DW-1:0] chan_level;
    logic [1:0] fifo_pop = 2'b00;
    logic [CW-1:0] fifo_thresh0 = '0, fifo_thresh1 = '0, fifo0_count, fifo1_count;
    logic [31:0] fifo0_rdata, fifo1_rdata;
    logic [7:0] irq_clr = '0, irq_status;
    logic busy;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_step_seq #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .seq_enable(seq_enable), .tag_enable(tag_enable),
        .power_down(power_down), .hw_trig(hw_trig), .step_en_wr(step_en_wr),
        .step_en_wdata(step_en_wdata), .step_en(step_en), .step_cfg(step_cfg),
        .step_dly(step_dly), .chan_level(chan_level), .fifo_pop(fifo_pop),
        .fifo_thresh0(fifo_thresh0), .fifo_thresh1(fifo_thresh1),
        .fifo0_rdata(fifo0_rdata), .fifo1_rdata(fifo1_rdata),
        .fifo0_count(fifo0_count), .fifo1_count(fifo1_count),
        .irq_clr(irq_clr), .irq_status(irq_status), .busy(busy));

    function automatic int lvl(int sel);
        return (sel < NC) ? 100 * sel + 37 : 0;
    endfunction

    function automatic int exp_avg(int p, int n, int code);
        int c = (code > 4) ? 4 : code;
        int sum = 0;
        for (int k = 0; k < (1 << c); k++) sum += (lvl(p) - lvl(n) + k) & 12'hFFF;
        return (sum >> c) & 12'hFFF;
    endfunction

    function automatic logic [31:0] exp_word(int p, int n, int code, int id, bit tag);
        logic [31:0] w = '0;
        w[11:0] = 12'(exp_avg(p, n, code));
        if (tag) w[19:16] = 4'(id);
        return w;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_step(int i, int mode, int code, int p, int n, bit q1, int od, int sd);
        logic [31:0] c = '0, d = '0;
        c[1:0] = 2'(mode); c[4:2] = 3'(code); c[18:15] = 4'(n);
        c[22:19] = 4'(p); c[26] = q1;
        d[17:0] = 18'(od); d[31:24] = 8'(sd);
        step_cfg[i*32 +: 32] = c;
        step_dly[i*32 +: 32] = d;
    endtask

    task automatic write_mask(logic [NS-1:0] m);
        @(negedge clk); step_en_wr = 1; step_en_wdata = m;
        @(negedge clk); step_en_wr = 0;
    endtask

    task automatic pop_check(int q, logic [31:0] exp, string req);
        @(negedge clk);
        check((q ? fifo1_rdata : fifo0_rdata) == exp, req, "popped word",
              q ? fifo1_rdata : fifo0_rdata, exp);
        fifo_pop[q] = 1'b1;
        @(negedge clk); fifo_pop[q] = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 8'hFF;
        @(negedge clk); irq_clr = 8'h00;
    endtask

    task automatic wait_eos();
        @(negedge clk);
        while (!irq_status[1]) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0 && irq_status == 0, "R1", "busy/irq after reset", {busy, irq_status}, 0);
        check(step_en == 0, "R1", "mask after reset", step_en, 0);
        check(fifo0_count == 0 && fifo1_count == 0 && fifo0_rdata == 0, "R1",
              "queues after reset", fifo0_count, 0);
    endtask

    task automatic t_order_avg_tag();
        tag_enable = 1;
        set_step(3, 0, 0, 2, 8, 0, 5, 1);
        set_step(7, 0, 2, 5, 1, 0, 0, 3);
        set_step(10, 0, 4, 0, 3, 0, 2, 0);
        write_mask(16'h0488);
        repeat (30) @(negedge clk);
        check(fifo0_count == 0 && !busy, "R2", "no start with seq_enable low", fifo0_count, 0);
        seq_enable = 1;
        wait_eos();
        check(!busy, "R10", "busy low at end of sequence", busy, 0);
        check(fifo0_count == 3, "R2", "three results", fifo0_count, 3);
        check(step_en == 0, "R3", "one-shot bits cleared", step_en, 0);
        pop_check(0, exp_word(2, 8, 0, 3, 1), "R2");
        pop_check(0, exp_word(5, 1, 2, 7, 1), "R4");
        pop_check(0, exp_word(0, 3, 4, 10, 1), "R4");
        seq_enable = 0;
        clear_irq();
    endtask

    task automatic t_route_notag();
        tag_enable = 0;
        set_step(1, 0, 7, 7, 6, 1, 3, 0);
        write_mask(16'h0002);
        seq_enable = 1;
        wait_eos();
        seq_enable = 0;
        check(fifo0_count == 0 && fifo1_count == 1, "R6", "routed to queue 1",
              fifo1_count, 1);
        pop_check(1, exp_word(7, 6, 4, 1, 0), "R5");
        clear_irq();
    endtask

    task automatic t_timing();
        int t0, t1, lo, hi;
        tag_enable = 1;
        set_step(2, 0, 1, 4, 8, 0, 40, 4);
        write_mask(16'h0004);
        seq_enable = 1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        t0 = cyc;
        while (fifo0_count == 0) @(negedge clk);
        t1 = cyc;
        lo = 40 + 2 * (4 + 13);
        hi = lo + 3 * 2 + 4;
        check((t1 - t0) >= lo && (t1 - t0) <= hi, "R7", "step latency", t1 - t0, lo);
        seq_enable = 0;
        wait_eos();
        pop_check(0, exp_word(4, 8, 1, 2, 1), "R7");
        clear_irq();
    endtask

    task automatic t_continuous();
        fifo_thresh0 = CW'(2);
        tag_enable = 1;
        set_step(0, 1, 0, 4, 8, 0, 2, 0);
        set_step(5, 0, 0, 6, 8, 0, 1, 0);
        write_mask(16'h0021);
        seq_enable = 1;
        @(negedge clk);
        while (!irq_status[3]) @(negedge clk);
        seq_enable = 0;
        check(fifo0_count == CW'(DEPTH), "R12", "count held at depth", fifo0_count, DEPTH);
        check(irq_status[2], "R11", "threshold flag", irq_status, 8'h04);
        check(step_en == 16'h0001, "R3", "continuous bit kept, one-shot cleared",
              step_en, 16'h0001);
        @(negedge clk);
        while (busy) @(negedge clk);
        write_mask('0);
        pop_check(0, exp_word(4, 8, 0, 0, 1), "R3");
        pop_check(0, exp_word(6, 8, 0, 5, 1), "R2");
        pop_check(0, exp_word(4, 8, 0, 0, 1), "R3");
        pop_check(0, exp_word(4, 8, 0, 0, 1), "R12");
        check(irq_status[4] == 0, "R13", "no underflow yet", irq_status[4], 0);
        pop_check(0, 32'h0, "R13");
        @(negedge clk);
        check(irq_status[4], "R13", "underflow flag", irq_status, 8'h10);
        fifo_thresh0 = '0;
        clear_irq();
        @(negedge clk);
        check(irq_status == 0, "R14", "flags cleared", irq_status, 0);
    endtask

    task automatic t_hwsync();
        tag_enable = 1;
        set_step(4, 2, 1, 3, 8, 1, 2, 1);
        write_mask(16'h0010);
        seq_enable = 1;
        repeat (100) @(negedge clk);
        check(busy && fifo1_count == 0, "R8", "held waiting for trigger", fifo1_count, 0);
        hw_trig = 1; @(negedge clk); hw_trig = 0;
        wait_eos();
        seq_enable = 0;
        check(fifo1_count == 1, "R8", "result after trigger", fifo1_count, 1);
        check(step_en == 0, "R3", "mode-2 bit cleared", step_en, 0);
        pop_check(1, exp_word(3, 8, 1, 4, 1), "R8");
        clear_irq();
    endtask

    task automatic t_powerdown();
        set_step(6, 0, 0, 1, 8, 0, 200, 0);
        write_mask(16'h0040);
        seq_enable = 1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        repeat (20) @(negedge clk);
        power_down = 1; seq_enable = 0;
        @(negedge clk);
        check(!busy, "R9", "busy low after power down", busy, 0);
        repeat (250) @(negedge clk);
        check(fifo0_count == 0 && !irq_status[1], "R9", "aborted step wrote nothing",
              fifo0_count, 0);
        check(step_en == 16'h0040, "R9", "aborted step keeps its bit", step_en, 16'h0040);
        seq_enable = 1;
        repeat (20) @(negedge clk);
        check(!busy, "R9", "no start while powered down", busy, 0);
        seq_enable = 0; power_down = 0;
        repeat (300) @(negedge clk);
        check(!busy && fifo0_count == 0, "R9", "no start with seq_enable low",
              fifo0_count, 0);
        write_mask('0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) chan_level[c*DW +: DW] = DW'(lvl(c));
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_order_avg_tag();
        t_route_notag();
        t_timing();
        t_continuous();
        t_hwsync();
        t_powerdown();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule